// File: doc/BRIEF.md
# Recoded-Table Distributed Arithmetic Dot-Product Unit

This block computes the inner product of a vector of signed input words with a fixed vector of signed coefficients. It uses no multiplier. The inputs are consumed one bit position per clock cycle, with every word of the vector handled in the same cycle. The bits at the current position, one from each word, form an address into a small table of precomputed coefficient sums. A shifting accumulator adds the selected table entry, with its sign applied, at the weight of that bit position.

The address is recoded by XOR-ing the bit of input 0 against the bits of the other inputs. Because of this the table holds only 2^(N-1) entries in place of 2^N. The bit of input 0 then decides whether the entry is added or subtracted. A single offset correction, taken from table entry 0, is folded in on the first cycle of every result. Software loads the table through a write port.

The number of input bits processed is chosen per operation. Only the most significant bits of each word are used, which trades precision for cycles and energy. A result with W bits takes W cycles.

Top module: `da_dotprod_unit`

## Requirements
- R1: While rst_n is low at a clock edge, and after it, busy and done are 0 and result is 0.
- R2: When start is high and busy is low at an edge, the unit captures x_vec and the effective width W, and busy goes high. done is high for exactly one cycle, W edges after the accepting edge. busy falls at that same edge.
- R3: For words x_k, each taken as 16-bit two's complement at x_vec[16k+15:16k], result equals the sum over k of c_k * (x_k >>> (16-W)). The result is 30-bit two's complement.
- R4: A write with tbl_we high stores tbl_data in table entry tbl_addr. For correct results, entry m must hold c_0 + sum over k=1..3 of (m[k-1] ? -c_k : +c_k), and address bit k-1 stands for (bit of input k) XOR (bit of input 0). Rewriting the table changes the coefficients of later results.
- R5: bits_cfg gives W. A value of 0 acts as W=1, and any value above 16 acts as W=16.
- R6: A start pulse while busy is high is ignored. The running operation finishes on time with a result computed from its own captured inputs.
- R7: result changes only at the edge where done rises, and holds otherwise, even when x_vec and bits_cfg change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| x_vec | input | 64 | Four packed signed input words, word k at bits 16k+15:16k |
| bits_cfg | input | 5 | Number of input bits to process per operation |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 3 | Table entry to write |
| tbl_data | input | 15 | Signed table entry value |
| result | output | 30 | Signed dot product of the last completed operation |
| done | output | 1 | One-cycle pulse when result is updated |
| busy | output | 1 | Operation in progress |

## Verification
The bench uses coefficient sets that include the most negative 12-bit value, and inputs that include 0x8000 and 0x7FFF. If the sign-bit cycle is mishandled, these give results with the wrong sign or an error of one input step. Width 1 makes the first cycle and the sign cycle the same cycle. A design that applies the offset twice, or skips it, then fails at once. Out-of-range widths check the clamping: a design that is off by one there stalls or ends early, and the per-cycle busy and done comparison catches it. A second start during a run, with different data, catches a unit that restarts or re-captures its inputs. Changing the inputs while idle catches a result register that is not held.

// File: rtl/da_pkg.sv
// Shared types for the distributed arithmetic dot-product unit.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package da_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } da_state_e;

endpackage

// File: rtl/da_coef_table.sv
// Register table of recoded partial sums; one write port, one combinational
// read port, plus a dedicated tap on entry 0 (the offset term).
// Assumes: writes are not issued while an operation is running.
module da_coef_table #(
    parameter int AW = 3,
    parameter int TW = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [TW-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic signed [TW-1:0] rdata,
    output logic signed [TW-1:0] offset
);
    localparam int DEPTH = 1 << AW;

    logic signed [TW-1:0] ent [DEPTH];

    for (genvar m = 0; m < DEPTH; m++) begin : g_ent
        // Hold one table entry; load it when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[m] <= '0;
            else if (we && (waddr == AW'(m)))
                ent[m] <= wdata;
        end
    end

    // Read path for the current bit-slice address and the offset tap.
    always_comb begin
        rdata  = ent[raddr];
        offset = ent[0];
    end
endmodule

// File: rtl/da_slice_recode.sv
// Picks one bit from every input word and forms the halved table address:
// address bit k-1 = bit(word k) XOR bit(word 0); add_sel = bit(word 0).
// Assumes: N_IN >= 2 and bit_idx < DW.
module da_slice_recode #(
    parameter int N_IN = 4,
    parameter int DW   = 16,
    localparam int AW  = N_IN - 1,
    localparam int IW  = $clog2(DW)
) (
    input  logic [N_IN*DW-1:0] x_vec,
    input  logic [IW-1:0]      bit_idx,
    output logic [AW-1:0]      addr,
    output logic               add_sel
);
    logic [N_IN-1:0] slice;

    for (genvar k = 0; k < N_IN; k++) begin : g_slice
        logic [DW-1:0] word;
        // Select the current bit position of word k.
        always_comb begin
            word     = x_vec[k*DW +: DW];
            slice[k] = word[bit_idx];
        end
    end

    // Recode the slice against word 0.
    always_comb begin
        add_sel = slice[0];
        addr    = slice[N_IN-1:1] ^ {AW{slice[0]}};
    end
endmodule

// File: rtl/da_shift_acc.sv
// Right-shifting accumulator. Each cycle it adds a signed term, placed at bit
// position shamt, then halves the sum. After shamt cycles it holds
// twice the dot product. The term is +/- the table entry (add_sel), negated
// again on the sign cycle, with the offset subtracted on the first cycle.
// Assumes: FW wide enough that no sum wraps; shamt stays constant in a run.
module da_shift_acc #(
    parameter int TW = 15,
    parameter int FW = 33,
    parameter int BW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 en,
    input  logic                 add_sel,
    input  logic                 sign_cyc,
    input  logic                 first_cyc,
    input  logic signed [TW-1:0] tab,
    input  logic signed [TW-1:0] offset,
    input  logic [BW-1:0]        shamt,
    output logic signed [FW-1:0] pre
);
    logic signed [FW-1:0] acc_q;
    logic signed [TW+1:0] t_sel, t_sgn, term;
    logic signed [FW-1:0] term_x;

    // Build the signed term for this cycle and the unshifted next sum.
    always_comb begin
        t_sel  = add_sel ? (TW+2)'(tab) : -((TW+2)'(tab));
        t_sgn  = sign_cyc ? -t_sel : t_sel;
        term   = first_cyc ? (t_sgn - (TW+2)'(offset)) : t_sgn;
        term_x = {{(FW-TW-2){term[TW+1]}}, term};
        pre    = acc_q + (term_x <<< shamt);
    end

    // Clear when idle, otherwise accumulate and shift right by one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            acc_q <= '0;
        else if (en)
            acc_q <= pre >>> 1;
    end
endmodule

// File: rtl/da_dotprod_unit.sv
// Distributed arithmetic dot-product unit with an offset-binary recoded table.
// Processes the top W bits of each word, LSB first, one bit per cycle, and
// pulses done with the result W cycles after start is accepted.
// Assumes: table loaded before start; N_IN >= 2.
module da_dotprod_unit
    import da_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int CW   = 12,
    parameter int DW   = 16,
    localparam int AW  = N_IN - 1,
    localparam int TW  = CW + $clog2(N_IN) + 1,
    localparam int RW  = CW + DW + $clog2(N_IN),
    localparam int FW  = RW + 3,
    localparam int BW  = $clog2(DW + 1),
    localparam int IW  = $clog2(DW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N_IN*DW-1:0]   x_vec,
    input  logic [BW-1:0]        bits_cfg,
    input  logic                 tbl_we,
    input  logic [AW-1:0]        tbl_addr,
    input  logic signed [TW-1:0] tbl_data,
    output logic signed [RW-1:0] result,
    output logic                 done,
    output logic                 busy
);
    da_state_e            st;
    logic [N_IN*DW-1:0]   x_q;
    logic [BW-1:0]        w_q, w_eff;
    logic [IW-1:0]        idx_q;
    logic [AW-1:0]        raddr;
    logic                 add_sel, first_c, last_c;
    logic signed [TW-1:0] tab, offset;
    logic signed [FW-1:0] pre, fin;

    // Clamp the requested width into 1..DW.
    always_comb begin
        if (bits_cfg == '0)
            w_eff = BW'(1);
        else if (bits_cfg > BW'(DW))
            w_eff = BW'(DW);
        else
            w_eff = bits_cfg;
    end

    // Decode first/sign cycle and the final scaled value.
    always_comb begin
        first_c = (idx_q == IW'(DW - int'(w_q)));
        last_c  = (idx_q == IW'(DW - 1));
        fin     = pre >>> 2;
        busy    = (st == ST_RUN);
    end

    da_coef_table #(.AW(AW), .TW(TW)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .waddr  (tbl_addr),
        .wdata  (tbl_data),
        .raddr  (raddr),
        .rdata  (tab),
        .offset (offset)
    );

    da_slice_recode #(.N_IN(N_IN), .DW(DW)) u_recode (
        .x_vec   (x_q),
        .bit_idx (idx_q),
        .addr    (raddr),
        .add_sel (add_sel)
    );

    da_shift_acc #(.TW(TW), .FW(FW), .BW(BW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (st == ST_IDLE),
        .en        (st == ST_RUN),
        .add_sel   (add_sel),
        .sign_cyc  (last_c),
        .first_cyc (first_c),
        .tab       (tab),
        .offset    (offset),
        .shamt     (w_q),
        .pre       (pre)
    );

    // Sequence an operation: capture, step bit index, publish result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            x_q    <= '0;
            w_q    <= BW'(1);
            idx_q  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        x_q   <= x_vec;
                        w_q   <= w_eff;
                        idx_q <= IW'(DW - int'(w_eff));
                        st    <= ST_RUN;
                    end
                end
                default: begin
                    if (last_c) begin
                        result <= fin[RW-1:0];
                        done   <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/da_dotprod_chk.sv
// Protocol checker for da_dotprod_unit, attached by bind.
// Assumes: synchronous active-low reset.
module da_dotprod_chk #(
    parameter int RW = 30,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [RW-1:0] result,
    input logic          done,
    input logic          busy
);
    int run_len;

    // Count consecutive busy cycles to bound operation length.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            run_len <= 0;
        else
            run_len <= run_len + 1;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R2
    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) run_len <= DW); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result)); // R7
    AST_RESET_IDLE: assert property (@(posedge clk) $past(!rst_n) |-> (!busy && !done)); // R1
endmodule

bind da_dotprod_unit da_dotprod_chk #(.RW(RW), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .result (result),
    .done   (done),
    .busy   (busy)
);

// File: tb/test_da_dotprod_unit.sv
module test_da_dotprod_unit;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int TW = 15;
    localparam int RW = 30;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [N*DW-1:0]      x_vec = '0;
    logic [4:0]           bits_cfg = 5'd16;
    logic                 tbl_we = 1'b0;
    logic [2:0]           tbl_addr = '0;
    logic signed [TW-1:0] tbl_data = '0;
    logic signed [RW-1:0] result;
    logic                 done, busy;

    int checks = 0;
    int errors = 0;
    int coef [N];
    string tag = "R1";

    // Reference model state.
    bit     m_busy = 0, m_done = 0;
    int     m_cnt = 0;
    longint m_res = 0, m_pend = 0;
    bit     chk_on = 0;

    always #5 clk = ~clk;

    da_dotprod_unit i_da_dotprod_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .x_vec(x_vec),
        .bits_cfg(bits_cfg), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .result(result), .done(done), .busy(busy)
    );

    function automatic int eff_w(logic [4:0] c); // R5 clamp
        if (c == 0) return 1;
        if (c > 16) return 16;
        return int'(c);
    endfunction

    function automatic longint ref_dot(logic [N*DW-1:0] xv, int w); // R3
        longint s = 0;
        for (int k = 0; k < N; k++) begin
            logic signed [DW-1:0] wv = xv[k*DW +: DW];
            longint v = longint'(wv);
            v = v >>> (DW - w);
            s += longint'(coef[k]) * v;
        end
        return s;
    endfunction

    // Cycle model: advances at each rising edge from stable inputs.
    always @(posedge clk) begin
        m_done = 0;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_res = 0;
        end else if (m_busy) begin
            if (m_cnt == 1) begin
                m_busy = 0; m_done = 1; m_res = m_pend;
            end else
                m_cnt--;
        end else if (start) begin
            m_busy = 1;
            m_cnt  = eff_w(bits_cfg);
            m_pend = ref_dot(x_vec, eff_w(bits_cfg));
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            string ctl = (tag == "R1") ? "R1" : "R2";
            checks += 3;
            if (busy !== m_busy) begin
                errors++;
                $display("FAIL %s busy act %0b exp %0b", ctl, busy, m_busy);
            end
            if (done !== m_done) begin
                errors++;
                $display("FAIL %s done act %0b exp %0b", ctl, done, m_done);
            end
            if (longint'(result) !== m_res) begin
                errors++;
                $display("FAIL %s result act %0d exp %0d", tag, result, m_res);
            end
        end
    end

    task automatic load_table(); // R4 entry layout
        for (int m = 0; m < 8; m++) begin
            int h = coef[0];
            for (int k = 1; k < N; k++)
                h += ((m >> (k - 1)) & 1) ? -coef[k] : coef[k];
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = 3'(m); tbl_data = TW'(h);
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic run_op(logic [N*DW-1:0] xv, logic [4:0] cfg);
        @(negedge clk);
        x_vec = xv; bits_cfg = cfg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (eff_w(cfg) + 2) @(negedge clk);
    endtask

    function automatic logic [N*DW-1:0] pack4(int a, int b, int c, int d);
        return {16'(d), 16'(c), 16'(b), 16'(a)};
    endfunction

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        chk_on = 1;
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        coef[0] = 1000; coef[1] = -2048; coef[2] = 2047; coef[3] = -7;
        tag = "R4";
        load_table();
        run_op(pack4(1, 0, 0, 0), 5'd16);
        run_op(pack4(0, 1, 0, 0), 5'd16);
        run_op(pack4(0, 0, 0, -1), 5'd16);

        tag = "R3";
        run_op(pack4(-32768, -32768, 32767, -32768), 5'd16);
        run_op(pack4(32767, -32768, -32768, 32767), 5'd16);
        run_op(pack4(1234, -5, 0, 77), 5'd16);
        for (int i = 0; i < 6; i++)
            run_op({$urandom, $urandom}, 5'd16);
        run_op(pack4(-32768, 12345, -1, 32767), 5'd1);
        run_op(pack4(-20000, 12345, -1, 32767), 5'd5);
        for (int w = 2; w <= 15; w += 3)
            run_op({$urandom, $urandom}, 5'(w));

        tag = "R5";
        run_op(pack4(-32768, 16384, -1, 9), 5'd0);
        run_op(pack4(-300, 16384, 700, 9), 5'd20);
        run_op(pack4(-300, -16384, 700, 9), 5'd31);

        tag = "R6";
        @(negedge clk);
        x_vec = pack4(500, -600, 700, -800); bits_cfg = 5'd12; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        x_vec = pack4(-1, -1, -1, -1); bits_cfg = 5'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (14) @(negedge clk);

        tag = "R4";
        coef[0] = -2048; coef[1] = 3; coef[2] = -1; coef[3] = 2047;
        load_table();
        run_op(pack4(-32768, 32767, 4096, -32768), 5'd16);
        run_op({$urandom, $urandom}, 5'd9);

        tag = "R7";
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            x_vec = {$urandom, $urandom}; bits_cfg = 5'($urandom);
        end
        repeat (2) @(negedge clk);

        chk_on = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule